// File: doc/BRIEF.md
# LCD Timing Enable Divider Tree

This block turns one reference tick stream into the timing enables an LCD controller needs. Both reference streams arrive as enable pulses in the fast system clock domain. One is an internal tick and the other comes from a slow external crystal, typically 32.768 kHz. An optional fixed divide-by-16 stage and an adjustable divide-by-(1+N) stage produce a module tick. Three branch dividers then derive a charge-pump tick, a frame-timing (base) tick and a blink tick from the module tick.

Each branch has its own power-of-two exponent field. Every divider is a synchronous counter that steps only on its input enable. Every output is a single-cycle enable pulse, so the block creates no derived clocks. When a setting changes, the counters it feeds restart from zero, so no shortened or stretched period occurs at the change. A global enable input stops the whole tree.

Top module: `lcdclk_tree`

## Requirements
- R1: When `src_ext` is 1 the tree counts `ext_tick` pulses; when it is 0 it counts `int_tick` pulses, and the unselected tick never causes a `mod_tick`.
- R2: `mod_tick` pulses once every (16 if `div16` is 1, else 1) × (1 + `adj`) selected reference ticks.
- R3: `cp_tick` pulses once every 2^(1 + `cpc`) module ticks.
- R4: `base_tick` pulses once every 8 × 2^`lclk` module ticks.
- R5: `blink_tick` pulses once every 2^(6 + `brate`) module ticks, that is a 2^(5 + `brate`) stage followed by a halving.
- R6: Every branch pulse is one system-clock cycle wide and occurs only in a cycle in which `mod_tick` is high.
- R7: In the cycle in which a branch's exponent field changes, that branch emits no pulse. The branch counter restarts from zero, so with a reference tick in every cycle, the first pulse after the change is sampled exactly one full new period later. A change of `src_ext`, `div16` or `adj` restarts the whole tree.
- R8: While `en` is 0 no output pulses and all counters are held at zero. After `en` rises, with a reference tick in every cycle, the first `cp_tick` appears P−1 cycles after the rising edge, where P is its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global run enable; low clears and silences the tree |
| src_ext | input | 1 | Reference select: 1 external tick, 0 internal tick |
| int_tick | input | 1 | Internal reference enable pulse |
| ext_tick | input | 1 | External (crystal) reference enable pulse |
| div16 | input | 1 | Inserts the fixed divide-by-16 stage |
| adj | input | 6 | Adjust divider: divide by 1 + adj |
| cpc | input | 2 | Charge-pump exponent field |
| lclk | input | 3 | Base-frequency exponent field |
| brate | input | 3 | Blink-rate exponent field |
| mod_tick | output | 1 | Module tick enable pulse |
| cp_tick | output | 1 | Charge-pump tick enable pulse |
| base_tick | output | 1 | Frame-timing tick enable pulse |
| blink_tick | output | 1 | Blink tick enable pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit adjust field, a 16-step prescaler and branch exponent offsets of 1, 3 and 6. This puts every field value within reach. Random settings are bounded so that each measured period stays at or below 4096 cycles. Directed cases then cover the extremes: the longest blink period, 8192 cycles with an every-cycle module tick, and the longest module period, 1024 cycles with both the prescaler and the full adjust value. The external reference is driven at one tick every third cycle, so a wrong source select shows up as a period off by a factor of three.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;
    localparam int ADJ_W     = 6;
    localparam int PRE_LOG2  = 4;
    localparam int CPC_W     = 2;
    localparam int LCLK_W    = 3;
    localparam int BRATE_W   = 3;
    localparam int CP_OFF    = 1;
    localparam int BASE_OFF  = 3;
    localparam int BLINK_OFF = 6;
    localparam int N_BR      = 3;
    localparam int BR_W      = BLINK_OFF + (2 ** BRATE_W) - 1;

    typedef struct packed {
        logic                src_ext;
        logic                div16;
        logic [ADJ_W-1:0]    adj;
        logic [CPC_W-1:0]    cpc;
        logic [LCLK_W-1:0]   lclk;
        logic [BRATE_W-1:0]  brate;
    } cfg_t;

    function automatic logic [BR_W-1:0] pow2_limit(input int e);
        return (BR_W'(1) << e) - BR_W'(1);
    endfunction
endpackage

// File: rtl/lcdclk_pulse_div.sv
module lcdclk_pulse_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         pulse
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        pulse = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (step) begin
            if (s_q.cnt >= limit) begin
                s_d.cnt = '0;
                pulse   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lcdclk_ref_stage.sv
module lcdclk_ref_stage
    import lcdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_ext,
    input  logic             int_tick,
    input  logic             ext_tick,
    input  logic             div16,
    input  logic [ADJ_W-1:0] adj,
    output logic             mod_tick
);
    localparam logic [PRE_LOG2-1:0] PRE_LIM = PRE_LOG2'((2 ** PRE_LOG2) - 1);

    logic                ref_tick;
    logic                pre_tick;
    logic [PRE_LOG2-1:0] pre_limit;

    always_comb begin
        ref_tick  = src_ext ? ext_tick : int_tick;
        pre_limit = div16 ? PRE_LIM : '0;
    end

    lcdclk_pulse_div #(.W(PRE_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (ref_tick),
        .limit (pre_limit),
        .pulse (pre_tick)
    );

    lcdclk_pulse_div #(.W(ADJ_W)) u_adj (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (pre_tick),
        .limit (adj),
        .pulse (mod_tick)
    );
endmodule

// File: rtl/lcdclk_tree.sv
module lcdclk_tree
    import lcdclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               src_ext,
    input  logic               int_tick,
    input  logic               ext_tick,
    input  logic               div16,
    input  logic [ADJ_W-1:0]   adj,
    input  logic [CPC_W-1:0]   cpc,
    input  logic [LCLK_W-1:0]  lclk,
    input  logic [BRATE_W-1:0] brate,
    output logic               mod_tick,
    output logic               cp_tick,
    output logic               base_tick,
    output logic               blink_tick
);
    typedef struct packed {
        logic run;
        cfg_t cfg;
    } st_t;

    st_t s_d, s_q;

    logic             clr_up;
    logic [N_BR-1:0]  fld_chg;
    logic [N_BR-1:0]  clr_br;
    logic [N_BR-1:0]  br_pulse;
    logic [BR_W-1:0]  br_limit [N_BR];

    always_comb begin
        s_d.run           = 1'b1;
        s_d.cfg.src_ext   = src_ext;
        s_d.cfg.div16     = div16;
        s_d.cfg.adj       = adj;
        s_d.cfg.cpc       = cpc;
        s_d.cfg.lclk      = lclk;
        s_d.cfg.brate     = brate;

        clr_up = !en || !s_q.run
              || (s_d.cfg.src_ext != s_q.cfg.src_ext)
              || (s_d.cfg.div16   != s_q.cfg.div16)
              || (s_d.cfg.adj     != s_q.cfg.adj);

        fld_chg[0] = (s_d.cfg.cpc   != s_q.cfg.cpc);
        fld_chg[1] = (s_d.cfg.lclk  != s_q.cfg.lclk);
        fld_chg[2] = (s_d.cfg.brate != s_q.cfg.brate);

        br_limit[0] = pow2_limit(CP_OFF    + int'(cpc));
        br_limit[1] = pow2_limit(BASE_OFF  + int'(lclk));
        br_limit[2] = pow2_limit(BLINK_OFF + int'(brate));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    lcdclk_ref_stage u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_up),
        .src_ext  (src_ext),
        .int_tick (int_tick),
        .ext_tick (ext_tick),
        .div16    (div16),
        .adj      (adj),
        .mod_tick (mod_tick)
    );

    for (genvar g = 0; g < N_BR; g++) begin : g_branch
        assign clr_br[g] = clr_up | fld_chg[g];
        lcdclk_pulse_div #(.W(BR_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_br[g]),
            .step  (mod_tick),
            .limit (br_limit[g]),
            .pulse (br_pulse[g])
        );
    end

    assign cp_tick    = br_pulse[0];
    assign base_tick  = br_pulse[1];
    assign blink_tick = br_pulse[2];
endmodule

// File: rtl/lcdclk_tree_chk.sv
module lcdclk_tree_chk
    import lcdclk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               src_ext,
    input logic               int_tick,
    input logic               ext_tick,
    input logic [CPC_W-1:0]   cpc,
    input logic [LCLK_W-1:0]  lclk,
    input logic [BRATE_W-1:0] brate,
    input logic               mod_tick,
    input logic               cp_tick,
    input logic               base_tick,
    input logic               blink_tick
);
    AST_MOD_FROM_SELECTED_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mod_tick |-> (src_ext ? ext_tick : int_tick)); // R1
    AST_CP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_tick |=> !cp_tick); // R3
    AST_BASE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick); // R4
    AST_BLINK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        blink_tick |=> !blink_tick); // R5
    AST_BRANCH_ON_MOD_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_tick || base_tick || blink_tick) |-> mod_tick); // R6
    AST_NO_CP_ON_FIELD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpc) |-> !cp_tick); // R7
    AST_NO_BASE_ON_FIELD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lclk) |-> !base_tick); // R7
    AST_NO_BLINK_ON_FIELD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(brate) |-> !blink_tick); // R7
    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(mod_tick || cp_tick || base_tick || blink_tick)); // R8
endmodule

bind lcdclk_tree lcdclk_tree_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .src_ext    (src_ext),
    .int_tick   (int_tick),
    .ext_tick   (ext_tick),
    .cpc        (cpc),
    .lclk       (lclk),
    .brate      (brate),
    .mod_tick   (mod_tick),
    .cp_tick    (cp_tick),
    .base_tick  (base_tick),
    .blink_tick (blink_tick)
);

// File: tb/tb_lcdclk_tree.sv
module tb_lcdclk_tree;
    localparam int CLK_PERIOD = 10;
    localparam int EXT_DIV    = 3;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       src_ext = 1'b0;
    logic       int_tick = 1'b1;
    logic       ext_tick = 1'b0;
    logic       div16 = 1'b0;
    logic [5:0] adj = '0;
    logic [1:0] cpc = '0;
    logic [2:0] lclk = '0;
    logic [2:0] brate = '0;
    logic       mod_tick, cp_tick, base_tick, blink_tick;

    int checks = 0;
    int errors = 0;
    int ext_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        ext_cnt  <= (ext_cnt == EXT_DIV - 1) ? 0 : ext_cnt + 1;
        ext_tick <= (ext_cnt == EXT_DIV - 1);
    end

    lcdclk_tree dut (
        .clk(clk), .rst_n(rst_n), .en(en), .src_ext(src_ext),
        .int_tick(int_tick), .ext_tick(ext_tick), .div16(div16), .adj(adj),
        .cpc(cpc), .lclk(lclk), .brate(brate), .mod_tick(mod_tick),
        .cp_tick(cp_tick), .base_tick(base_tick), .blink_tick(blink_tick)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mod_period(input bit s, input bit d, input int a);
        return (s ? EXT_DIV : 1) * (d ? 16 : 1) * (1 + a);
    endfunction

    // Measures pulse-to-pulse intervals of the outputs selected by mask
    // (bit0 mod, bit1 cp, bit2 base, bit3 blink) after a restart through en.
    task automatic run_case(input bit [3:0] mask);
        int pm, exp [4], t1 [4], t2 [4], n [4], lim, t, viol, act;
        bit [3:0] v;
        string req;
        pm     = mod_period(src_ext, div16, int'(adj));
        exp[0] = pm;
        exp[1] = pm << (1 + int'(cpc));
        exp[2] = (pm * 8) << int'(lclk);
        exp[3] = pm << (6 + int'(brate));
        lim = 0;
        for (int i = 0; i < 4; i++) begin
            n[i] = 0; t1[i] = 0; t2[i] = 0;
            if (mask[i] && exp[i] > lim) lim = exp[i];
        end
        lim  = 2 * lim + 64;
        viol = 0;
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
        t = 0;
        while (t < lim) begin
            @(negedge clk);
            t++;
            v = {blink_tick, base_tick, cp_tick, mod_tick};
            if ((v[1] || v[2] || v[3]) && !v[0]) viol++;
            for (int i = 0; i < 4; i++) begin
                if (v[i]) begin
                    if (n[i] == 0) t1[i] = t;
                    else if (n[i] == 1) t2[i] = t;
                    n[i]++;
                end
            end
            if ((!mask[0] || n[0] >= 2) && (!mask[1] || n[1] >= 2) &&
                (!mask[2] || n[2] >= 2) && (!mask[3] || n[3] >= 2)) break;
        end
        for (int i = 0; i < 4; i++) begin
            if (mask[i]) begin
                act = (n[i] >= 2) ? t2[i] - t1[i] : -1;
                case (i)
                    0: req = src_ext ? "R1 R2 module tick" : "R2 module tick";
                    1: req = "R3 charge-pump tick";
                    2: req = "R4 base tick";
                    default: req = "R5 blink tick";
                endcase
                chk(act == exp[i], req, act, exp[i]);
            end
        end
        chk(viol == 0, "R6 branch pulse outside module tick", viol, 0);
    endtask

    task automatic cycles_to_cp(output int t, input int lim);
        t = 0;
        while (t < lim) begin
            @(negedge clk);
            t++;
            if (cp_tick) return;
        end
        t = -1;
    endtask

    initial begin
        int pm, maxb, t, cnt;
        void'($urandom(32'd8191));
        en = 1'b1;
        repeat (4) @(negedge clk);
        // Reset state: no pulses while reset is held
        chk({mod_tick, cp_tick, base_tick, blink_tick} == 4'b0, "R8 reset quiet",
            {mod_tick, cp_tick, base_tick, blink_tick}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Directed: longest blink with an every-cycle module tick
        src_ext = 0; div16 = 0; adj = 0; cpc = 3; lclk = 7; brate = 7;
        run_case(4'b1111);
        // Directed: longest module period (prescaler plus full adjust)
        div16 = 1; adj = 63; cpc = 0; lclk = 0; brate = 0;
        run_case(4'b0111);
        // Directed: external source, minimum fields
        src_ext = 1; div16 = 0; adj = 0; cpc = 0; lclk = 0; brate = 0;
        run_case(4'b1111);

        // Random settings, periods bounded to 4096 cycles
        for (int k = 0; k < 10; k++) begin
            src_ext = 1'($urandom % 2);
            div16   = (($urandom % 4) == 0);
            if (div16) begin
                src_ext = 0;
                adj = 6'($urandom % 3);
            end else begin
                adj = 6'($urandom % 16);
            end
            pm   = mod_period(src_ext, div16, int'(adj));
            cpc  = 2'($urandom % 4);
            maxb = 0;
            while (maxb < 7 && (pm << (4 + maxb)) <= 4096) maxb++;
            lclk = 3'($urandom % (maxb + 1));
            maxb = 0;
            while (maxb < 7 && (pm << (7 + maxb)) <= 4096) maxb++;
            brate = 3'($urandom % (maxb + 1));
            run_case(4'b1111);
        end

        // R7: charge-pump field change mid-period restarts its count
        src_ext = 0; div16 = 0; adj = 0; cpc = 2; lclk = 1; brate = 0;
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
        repeat (5) @(negedge clk);
        cpc = 3;
        cycles_to_cp(t, 100);
        chk(t == 16, "R7 cp restart after field change", t, 16);
        // R7: base field change restarts base branch
        repeat (7) @(negedge clk);
        lclk = 2;
        t = 0;
        while (t < 200) begin
            @(negedge clk);
            t++;
            if (base_tick) break;
        end
        chk(t == 32, "R7 base restart after field change", t, 32);

        // R8: disabled tree stays silent
        @(negedge clk) en = 1'b0;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (mod_tick || cp_tick || base_tick || blink_tick) cnt++;
        end
        chk(cnt == 0, "R8 pulses while disabled", cnt, 0);
        // R8: first cp pulse P-1 cycles after enable rises (P = 4)
        cpc = 1;
        @(negedge clk);
        en = 1'b1;
        cycles_to_cp(t, 100);
        chk(t == 3, "R8 first cp after enable", t, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule